// File: doc/BRIEF.md
# Digit-Serial Adder With Lane-Aligned Word Boundaries

This block adds two unsigned operand streams a digit at a time. A digit holds `DIGIT_W` bits, and each stream carries a sequence of `WORD_W`-bit words, least significant bit first. Lane i of a digit holds stream bit d·DIGIT_W+i, where d is the digit's index since reset. Lane 0 is the least significant bit of the digit.

Inside a digit, the carry runs combinationally from lane to lane. Between digits it passes through a single register, from the top lane back to lane 0. At every bit where a new word begins, the carry into that lane is forced to zero. This keeps one word's carry out of the next word.

The word length does not need to be a multiple of the digit size. In that case the lane where a word starts moves from digit to digit. The pattern repeats every lcm(WORD_W, DIGIT_W) bits. A small counter of valid digits tracks where the pattern stands, so idle cycles between digits are harmless. When the word length equals the digit size, the block is a plain ripple-carry adder with a carry-in of zero, and the registered top carry gives the word's overflow.

Top module: `digit_serial_adder`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `outValid`, `outSum`, `outWordStart` and `outCarry` are all 0.
- R2: Each digit accepted with `inValid` high produces exactly one result, with `outValid` high one clock later. While `inValid` stays low, `outValid` is low and `outSum` and `outCarry` hold their values.
- R3: Take the sum stream, lane i of digit d being stream bit d·DIGIT_W+i. Cut it into WORD_W-bit words from bit 0, LSB first. Each word equals (A+B) mod 2^WORD_W for the matching operand words.
- R4: A carry produced in the top lane reaches lane 0 of the next valid digit when both bits belong to the same word. An example is a word of all ones plus 1, spread across digits.
- R5: No carry crosses a word boundary. The lane that holds bit 0 of a word computes A xor B for that bit, whatever the previous word produced.
- R6: Bit i of `outWordStart` is 1 exactly when lane i of that result holds bit 0 of a word. The first valid digit after reset starts a word in lane 0. With WORD_W=4 and DIGIT_W=3, successive digits mark lane 0, then lane 1, then lane 2, then no lane, and the pattern then repeats.
- R7: Cycles with `inValid` low advance neither the word-boundary pattern nor the carry register. A stream with idle cycles between its digits gives the same results as the same stream sent without gaps.
- R8: `outCarry` is the carry leaving the top lane of the most recent result. For a top-lane bit at word position k, that is bit k+1 of the sum of the low k+1 bits of A and B.
- R9: Reset in the middle of a word discards the partial word. The next valid digit starts a new word in lane 0 with a carry of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | The current digit of A and B is present |
| inA | input | DIGIT_W | Operand A digit, lane 0 = earliest bit |
| inB | input | DIGIT_W | Operand B digit, lane 0 = earliest bit |
| outValid | output | 1 | A result digit is present |
| outSum | output | DIGIT_W | Sum digit, lane 0 = earliest bit |
| outWordStart | output | DIGIT_W | Lane i holds bit 0 of a word |
| outCarry | output | 1 | Carry out of the top lane of the last result |

## Verification
A position counter that has slipped shows at once in `outWordStart`, on the first result after the slip. It also corrupts the sum of the word that straddles the misplaced boundary.

A carry register that has been lost or gained shows in the next result. It flips lane 0 of a word's inner bit, or the starting bit of a word when the boundary reset has failed. Patterns of all ones, of ones plus one, and of alternating full and empty words make such carries appear in the first or second digit after the fault. The bench also feeds random words, both with idle gaps and without.

// File: rtl/dsadd_pkg.sv
package dsadd_pkg;

  // Strobes sent from control to the datapath.
  typedef struct packed {
    logic advance;   // a digit is accepted this cycle
  } dsCtrl_t;

  function automatic int gcdOf(input int x, input int y);
    int p;
    int q;
    int t;
    p = x;
    q = y;
    while (q != 0) begin
      t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  function automatic int lcmOf(input int x, input int y);
    return (x / gcdOf(x, y)) * y;
  endfunction

endpackage

// File: rtl/dsadd_ctrl.sv
module dsadd_ctrl
  import dsadd_pkg::*;
#(
  parameter int WORD_W  = 4,
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output dsCtrl_t            ctrl,
  output logic [DIGIT_W-1:0] laneReset
);

  localparam int SPAN   = lcmOf(WORD_W, DIGIT_W);
  localparam int CYCLES = SPAN / DIGIT_W;
  localparam int CNT_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cycleCnt;

  // Counts valid digits modulo the length of the boundary pattern.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (inValid) begin
      if (cycleCnt == CNT_W'(CYCLES - 1)) cycleCnt <= '0;
      else                                cycleCnt <= cycleCnt + 1'b1;
    end
  end

  // A lane is reset when its stream bit lands on word position 0.
  for (genvar i = 0; i < DIGIT_W; i++) begin : gLaneSel
    assign laneReset[i] = (((int'(cycleCnt) * DIGIT_W) + i) % WORD_W) == 0;
  end

  assign ctrl.advance = inValid;

endmodule

// File: rtl/dsadd_path.sv
module dsadd_path
  import dsadd_pkg::*;
#(
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dsCtrl_t            ctrl,
  input  logic [DIGIT_W-1:0] laneReset,
  input  logic [DIGIT_W-1:0] inA,
  input  logic [DIGIT_W-1:0] inB,
  output logic               outValid,
  output logic [DIGIT_W-1:0] outSum,
  output logic [DIGIT_W-1:0] outWordStart,
  output logic               outCarry
);

  logic               carryQ;
  logic [DIGIT_W:0]   chain;
  logic [DIGIT_W-1:0] laneCin;
  logic [DIGIT_W-1:0] sumD;

  assign chain[0] = carryQ;

  for (genvar i = 0; i < DIGIT_W; i++) begin : gLane
    assign laneCin[i]  = laneReset[i] ? 1'b0 : chain[i];
    assign sumD[i]     = inA[i] ^ inB[i] ^ laneCin[i];
    assign chain[i+1]  = (inA[i] & inB[i]) | (laneCin[i] & (inA[i] ^ inB[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ       <= 1'b0;
      outValid     <= 1'b0;
      outSum       <= '0;
      outWordStart <= '0;
    end else begin
      outValid <= ctrl.advance;
      if (ctrl.advance) begin
        carryQ       <= chain[DIGIT_W];
        outSum       <= sumD;
        outWordStart <= laneReset;
      end
    end
  end

  assign outCarry = carryQ;

endmodule

// File: rtl/digit_serial_adder.sv
module digit_serial_adder
  import dsadd_pkg::*;
#(
  parameter int WORD_W  = 4,
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DIGIT_W-1:0] inA,
  input  logic [DIGIT_W-1:0] inB,
  output logic               outValid,
  output logic [DIGIT_W-1:0] outSum,
  output logic [DIGIT_W-1:0] outWordStart,
  output logic               outCarry
);

  dsCtrl_t            ctrl;
  logic [DIGIT_W-1:0] laneReset;

  dsadd_ctrl #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ctrl(ctrl), .laneReset(laneReset)
  );

  dsadd_path #(.DIGIT_W(DIGIT_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .laneReset(laneReset),
    .inA(inA), .inB(inB),
    .outValid(outValid), .outSum(outSum),
    .outWordStart(outWordStart), .outCarry(outCarry)
  );

endmodule

// File: rtl/digit_serial_adder_chk.sv
module digit_serial_adder_chk #(
  parameter int WORD_W  = 4,
  parameter int DIGIT_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [DIGIT_W-1:0] inA,
  input logic [DIGIT_W-1:0] inB,
  input logic               outValid,
  input logic [DIGIT_W-1:0] outSum,
  input logic [DIGIT_W-1:0] outWordStart,
  input logic               outCarry
);

  // Independent model: the word position of lane 0, advanced by one digit.
  int                 posQ;
  logic [DIGIT_W-1:0] expStart;
  logic [DIGIT_W-1:0] expStartQ;

  always_comb begin
    for (int i = 0; i < DIGIT_W; i++) expStart[i] = ((posQ + i) % WORD_W) == 0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ      <= 0;
      expStartQ <= '0;
    end else if (inValid) begin
      posQ      <= (posQ + DIGIT_W) % WORD_W;
      expStartQ <= expStart;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outSum) && $stable(outCarry)));

  assert_start_pattern_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outWordStart == expStartQ));

  for (genvar i = 0; i < DIGIT_W; i++) begin : gStartLane
    assert_no_carry_leak_R5: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && outWordStart[i]) |-> (outSum[i] == ($past(inA[i]) ^ $past(inB[i]))));
  end

endmodule

bind digit_serial_adder digit_serial_adder_chk #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) uChk (.*);

// File: tb/sim_digit_serial_adder.sv
`timescale 1ns/1ps
module sim_digit_serial_adder;

  localparam int W = 4;
  localparam int J = 3;

  function automatic int gcdB(input int x, input int y);
    int p;
    int q;
    int t;
    p = x;
    q = y;
    while (q != 0) begin
      t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  localparam int L   = (W / gcdB(W, J)) * J;
  localparam int WPG = L / W;   // words per full pattern period

  typedef struct packed {
    logic [J-1:0] sum;
    logic [J-1:0] start;
    logic         cout;
  } exp_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [J-1:0] inA = '0;
  logic [J-1:0] inB = '0;
  logic         outValid;
  logic [J-1:0] outSum;
  logic [J-1:0] outWordStart;
  logic         outCarry;

  int   checks = 0;
  int   fails  = 0;
  exp_t scoreQ[$];
  logic [J-1:0] lastSum = '0;
  logic         lastCarry = 1'b0;

  always #4 clk = ~clk;

  digit_serial_adder #(.WORD_W(W), .DIGIT_W(J)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inA(inA), .inB(inB),
    .outValid(outValid), .outSum(outSum), .outWordStart(outWordStart),
    .outCarry(outCarry)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: builds operand words, pushes expected digits, streams them.
  // pattern 0 random, 1 ones+ones, 2 ones+1, 3 alternating full/empty words
  task automatic sendWords(input int groups, input int pattern, input int gapEvery,
                           input int maxDigits);
    logic aB[$];
    logic bB[$];
    logic sB[$];
    logic stB[$];
    logic cB[$];
    int unsigned mask;
    int nd;
    mask = (1 << W) - 1;
    for (int w = 0; w < groups * WPG; w++) begin
      int unsigned a;
      int unsigned b;
      int unsigned s;
      case (pattern)
        1:       begin a = mask; b = mask; end
        2:       begin a = mask; b = 1; end
        3:       begin a = (w % 2 == 0) ? mask : 0; b = a; end
        default: begin a = $urandom & mask; b = $urandom & mask; end
      endcase
      s = (a + b) & mask;
      for (int k = 0; k < W; k++) begin
        int unsigned m;
        m = (k + 1 >= 32) ? 32'hffffffff : ((1 << (k + 1)) - 1);
        aB.push_back(a[k]);
        bB.push_back(b[k]);
        sB.push_back(s[k]);
        stB.push_back(k == 0);
        cB.push_back(1'(((a & m) + (b & m)) >> (k + 1)));
      end
    end
    nd = aB.size() / J;
    if (maxDigits > 0 && maxDigits < nd) nd = maxDigits;
    for (int d = 0; d < nd; d++) begin
      exp_t e;
      logic [J-1:0] va;
      logic [J-1:0] vb;
      for (int i = 0; i < J; i++) begin
        va[i]      = aB[d*J+i];
        vb[i]      = bB[d*J+i];
        e.sum[i]   = sB[d*J+i];
        e.start[i] = stB[d*J+i];
      end
      e.cout = cB[d*J+J-1];
      scoreQ.push_back(e);
      @(negedge clk);
      inValid = 1'b1;
      inA = va;
      inB = vb;
      if (gapEvery > 0 && (d % gapEvery) == 0) begin
        @(negedge clk);
        inValid = 1'b0;
        inA = ~va;
        inB = vb;
        @(negedge clk);
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(scoreQ.size() == 0, "R2 one result per digit", scoreQ.size(), 0);
  endtask

  // Monitor: compares results against the scoreboard away from the edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (scoreQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", int'(outSum), 0);
        end else begin
          exp_t e;
          e = scoreQ.pop_front();
          check(outSum == e.sum, "R3 sum digit", int'(outSum), int'(e.sum));
          check(outWordStart == e.start, "R6 word start lanes",
                int'(outWordStart), int'(e.start));
          check(outCarry == e.cout, "R8 top lane carry", int'(outCarry), int'(e.cout));
        end
      end else begin
        check(outSum == lastSum && outCarry == lastCarry, "R2 idle hold",
              int'({outCarry, outSum}), int'({lastCarry, lastSum}));
      end
    end
    lastSum   = outSum;
    lastCarry = outCarry;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outSum == '0 && outWordStart == '0 && outCarry == 1'b0,
          "R1 reset state", int'({outValid, outWordStart, outSum, outCarry}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outSum == '0 && outWordStart == '0 && outCarry == 1'b0,
          "R1 after release", int'({outValid, outWordStart, outSum, outCarry}), 0);

    sendWords(2, 1, 0, 0);   // R3 R4 full carries
    sendWords(2, 2, 0, 0);   // R4 carry ripples across digits
    sendWords(3, 3, 0, 0);   // R5 no carry leak between words
    sendWords(20, 0, 0, 0);  // R3 random words
    sendWords(10, 0, 2, 0);  // R7 idle gaps between digits
    sendWords(4, 2, 1, 0);   // R7 gaps while a carry is pending

    // R9: stop mid-word, reset, then a fresh stream must start at lane 0.
    sendWords(1, 1, 0, 1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outCarry == 1'b0, "R9 reset clears carry",
          int'({outValid, outCarry}), 0);
    sendWords(2, 2, 0, 0);   // R9 alignment and carry restart
    sendWords(5, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule